// File: doc/BRIEF.md
# Key-Protected Reset Controller

This block generates the two reset domains of a sensor front end and records why the last reset happened. Three causes feed it: a power-on reset input, an active-low external reset pin, and a software request made over a small register bus. A power-on or pin reset clears everything. A software reset clears only the digital domain and leaves the retention domain running, so sensor bias and switch settings stay in place.

Software can only request a reset after it unlocks the block with a key, and each key opens the lock once. Any other bus write made before the request locks the block again. A sticky cause register holds one flag per reset source. Each flag is cleared by writing one to it. Neither a software reset nor a pin reset clears this register, so the host can read it after either one.

Top module: `rstgate_top`

## Requirements
- R1: Register map on a 12-bit address. The unlock key register is at 0x0A5C and reads 0. The software reset register is at 0x0424; bit 0 is its only bit and bits 15:1 read 0. The cause register is at 0x0A40, with bit 0 for power-on, bit 1 for the pin and bit 3 for software; bit 2 and bits 15:4 read 0. Unmapped addresses read 0. Read data is combinational while `bus_re_i` is high.
- R2: While `por_i` is high, both reset outputs are high. They stay high for exactly 8 clock cycles after the last rising edge that sees `por_i` high. The cause register then reads 0x0001 and the software reset register reads 0x0001.
- R3: A low level on `ext_rst_n_i` asserts both outputs in the same cycle, with no clock edge needed. The pin passes through a two-flop synchroniser. After the pin returns high, both outputs fall at the 10th rising edge. The pin sets cause bit 1 and leaves the other cause bits unchanged.
- R4: First write 0x12EA to 0x0A5C. If the next bus write puts 0 in bit 0 of 0x0424, a software reset starts. `rst_dig_o` goes high after that write's clock edge and stays high for exactly 8 cycles. `rst_ret_o` stays low throughout.
- R5: A software reset sets cause bit 3. The software reset register reads 0x0000 while the software reset is active and reads 0x0001 again afterwards.
- R6: A key write with any value other than 0x12EA leaves the block locked. A write to 0x0424 while the block is locked has no effect.
- R7: After an unlock, a write to any address other than 0x0424 or 0x0A5C locks the block again.
- R8: The key works once. Any write to 0x0424 uses it up, including a write with bit 0 = 1, which starts no reset. Each software reset therefore needs a fresh key.
- R9: Writing 1 to a cause bit clears it. Writing 0 leaves it unchanged.
- R10: Bus writes are ignored while `rst_dig_o` is high. This covers key writes and cause register writes.
- R11: A software reset clears no cause bit, and a pin reset clears no other cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| bus_addr_i | input | 12 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 16 | Read data |
| rst_dig_o | output | 1 | Digital-domain reset, active high |
| rst_ret_o | output | 1 | Retention-domain reset, active high |

## Verification
Lock state cannot be read over the bus. A lock that is wrong only shows up when a later write to 0x0424 either starts a reset it should not, or fails to start one it should. The bench therefore follows every key sequence with that write and watches `rst_dig_o` on the next cycle. A hold counter that is wrong shows up as a reset pulse whose length is not exactly 8 cycles, so the length is counted edge by edge. A wrong cause flag is visible as soon as the cause register is read.

// File: rtl/rstgate_pkg.sv
package rstgate_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] ADDR_KEY   = 12'hA5C;
    localparam logic [ADDR_W-1:0] ADDR_SWRST = 12'h424;
    localparam logic [ADDR_W-1:0] ADDR_CAUSE = 12'hA40;

    localparam logic [DATA_W-1:0] UNLOCK_CODE = 16'h12EA;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_KEY,
        SEL_SWRST,
        SEL_CAUSE
    } reg_sel_e;

    // one sticky flag per reset source
    typedef struct packed {
        logic sw;
        logic ext;
        logic por;
    } cause_t;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            ADDR_KEY:   s = SEL_KEY;
            ADDR_SWRST: s = SEL_SWRST;
            ADDR_CAUSE: s = SEL_CAUSE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cause(input cause_t c);
        logic [DATA_W-1:0] v;
        v    = '0;
        v[0] = c.por;
        v[1] = c.ext;
        v[3] = c.sw;
        return v;
    endfunction

    function automatic cause_t cause_from_word(input logic [3:0] w);
        cause_t c;
        c.por = w[0];
        c.ext = w[1];
        c.sw  = w[3];
        return c;
    endfunction

endpackage

// File: rtl/rstgate_sync.sv
module rstgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // stage 0 samples the pin, later stages re-time it
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstgate_hold.sv
module rstgate_hold #(
    parameter int HOLD  = 8,
    localparam int CNT_W = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (trig)        cnt <= CNT_W'(HOLD);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/rstgate_keylock.sv
module rstgate_keylock
    import rstgate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    output logic    unlocked,
    output logic    sw_fire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (wr.we) begin
            case (wr.sel)
                SEL_KEY: unlocked <= (wr.data == UNLOCK_CODE);
                default: unlocked <= 1'b0;   // request register uses the key, others relock
            endcase
        end
    end

    assign sw_fire = wr.we && (wr.sel == SEL_SWRST) && unlocked && !wr.data[0];
endmodule

// File: rtl/rstgate_cause.sv
module rstgate_cause
    import rstgate_pkg::*;
(
    input  logic   clk,
    input  logic   por,
    input  logic   ext_evt,
    input  logic   sw_evt,
    input  cause_t clr,
    output cause_t q
);
    cause_t nxt;

    always_comb begin
        nxt     = q;
        nxt.por = q.por & ~clr.por;
        nxt.ext = (q.ext & ~clr.ext) | ext_evt;
        nxt.sw  = (q.sw  & ~clr.sw)  | sw_evt;
    end

    always_ff @(posedge clk) begin
        if (por) q <= '{sw: 1'b0, ext: 1'b0, por: 1'b1};
        else     q <= nxt;
    end
endmodule

// File: rtl/rstgate_top.sv
module rstgate_top
    import rstgate_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              ext_rst_n_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              rst_dig_o,
    output logic              rst_ret_o
);
    logic     pin_sync;
    logic     ext_low;
    logic     hard_trig;
    logic     hard_busy;
    logic     sw_busy;
    logic     sw_fire;
    logic     unlocked;
    reg_sel_e sel;
    bus_wr_t  wr;
    cause_t   cause_q;
    cause_t   clr;

    rstgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (por_i),
        .din  (ext_rst_n_i),
        .dout (pin_sync)
    );

    assign ext_low   = ~pin_sync;
    assign hard_trig = por_i | ext_low;

    rstgate_hold #(.HOLD(HOLD_CYCLES)) u_hard_hold (
        .clk  (clk),
        .rst  (1'b0),
        .trig (hard_trig),
        .busy (hard_busy)
    );

    // assertion is combinational from the inputs, release is via the counter
    assign rst_ret_o = por_i | ~ext_rst_n_i | ext_low | hard_busy;
    assign rst_dig_o = rst_ret_o | sw_busy;

    assign sel     = decode_addr(bus_addr_i);
    assign wr.we   = bus_we_i & ~rst_dig_o;
    assign wr.sel  = sel;
    assign wr.data = bus_wdata_i;

    rstgate_keylock u_lock (
        .clk      (clk),
        .rst      (hard_trig),
        .wr       (wr),
        .unlocked (unlocked),
        .sw_fire  (sw_fire)
    );

    rstgate_hold #(.HOLD(HOLD_CYCLES)) u_sw_hold (
        .clk  (clk),
        .rst  (hard_trig),
        .trig (sw_fire),
        .busy (sw_busy)
    );

    assign clr = (wr.we && sel == SEL_CAUSE) ? cause_from_word(bus_wdata_i[3:0]) : '0;

    rstgate_cause u_cause (
        .clk     (clk),
        .por     (por_i),
        .ext_evt (ext_low),
        .sw_evt  (sw_fire),
        .clr     (clr),
        .q       (cause_q)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_re_i) begin
            case (sel)
                SEL_SWRST: bus_rdata_o = {{(DATA_W-1){1'b0}}, ~sw_busy};
                SEL_CAUSE: bus_rdata_o = pack_cause(cause_q);
                default:   bus_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/rstgate_chk.sv
module rstgate_chk
    import rstgate_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    localparam int RUN_W = $clog2(HOLD_CYCLES + 2) + 1
) (
    input logic              clk,
    input logic              por_i,
    input logic              rst_dig_o,
    input logic              rst_ret_o,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              clr_sw_bit,
    input logic              unlocked,
    input logic              sw_busy,
    input cause_t            cause_q
);
    logic [RUN_W-1:0] sw_run;

    always_ff @(posedge clk) begin
        if (por_i)        sw_run <= '0;
        else if (sw_busy) sw_run <= sw_run + 1'b1;
        else              sw_run <= '0;
    end

    // R2: leaving power-on reset yields only the power-on flag, retention still held
    a_r2_por_exit: assert property (@(posedge clk) disable iff (por_i)
        $fell(por_i) |-> (cause_q == '{sw: 1'b0, ext: 1'b0, por: 1'b1}) && rst_ret_o);

    // R4: software reset pulse never exceeds the hold length
    a_r4_sw_len: assert property (@(posedge clk) disable iff (por_i)
        sw_busy |-> (sw_run < RUN_W'(HOLD_CYCLES)));

    // R4: starting a software reset leaves the retention domain alone
    a_r4_ret_quiet: assert property (@(posedge clk) disable iff (por_i)
        $rose(sw_busy) |-> !rst_ret_o);

    // R5: a software reset always leaves its cause flag behind
    a_r5_flag_set: assert property (@(posedge clk) disable iff (por_i)
        $rose(sw_busy) |-> cause_q.sw);

    // R6: a request while locked starts nothing
    a_r6_locked_ignored: assert property (@(posedge clk) disable iff (por_i)
        (bus_we_i && !rst_dig_o && bus_addr_i == ADDR_SWRST && !unlocked) |=> !sw_busy);

    // R7: a write outside the key register leaves the block locked
    a_r7_relock: assert property (@(posedge clk) disable iff (por_i)
        (bus_we_i && !rst_dig_o && bus_addr_i != ADDR_KEY) |=> !unlocked);

    // R9: writing one to the software flag clears it
    a_r9_w1c: assert property (@(posedge clk) disable iff (por_i)
        (bus_we_i && !rst_dig_o && bus_addr_i == ADDR_CAUSE && clr_sw_bit) |=> !cause_q.sw);
endmodule

bind rstgate_top rstgate_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .rst_dig_o  (rst_dig_o),
    .rst_ret_o  (rst_ret_o),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .clr_sw_bit (bus_wdata_i[3]),
    .unlocked   (unlocked),
    .sw_busy    (sw_busy),
    .cause_q    (cause_q)
);

// File: tb/rstgate_top_bench.sv
`timescale 1ns/1ps
module rstgate_top_bench;
    localparam logic [11:0] A_KEY   = 12'hA5C;
    localparam logic [11:0] A_SWRST = 12'h424;
    localparam logic [11:0] A_CAUSE = 12'hA40;
    localparam logic [15:0] KEY     = 16'h12EA;

    logic        clk = 1'b0;
    logic        por_i = 1'b1;
    logic        ext_rst_n_i = 1'b1;
    logic [11:0] bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic        bus_we_i = 1'b0;
    logic        bus_re_i = 1'b0;
    logic [15:0] bus_rdata_o;
    logic        rst_dig_o;
    logic        rst_ret_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rstgate_top u_rstgate_top (
        .clk         (clk),
        .por_i       (por_i),
        .ext_rst_n_i (ext_rst_n_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_we_i    (bus_we_i),
        .bus_re_i    (bus_re_i),
        .bus_rdata_o (bus_rdata_o),
        .rst_dig_o   (rst_dig_o),
        .rst_ret_o   (rst_ret_o)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr_i  = a;
        bus_wdata_i = d;
        bus_we_i    = 1'b1;
        @(negedge clk);
        bus_we_i    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        bus_addr_i = a;
        bus_re_i   = 1'b1;
        #0.5;
        d          = bus_rdata_o;
        bus_re_i   = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] d;
        bus_read(a, d);
        chk(req, $sformatf("read %h", a), d, exp);
    endtask

    task automatic expect_no_reset(input string req);
        for (int i = 0; i < 3; i++) begin
            chk(req, "rst_dig_o stays low", {15'b0, rst_dig_o}, 16'h0);
            @(negedge clk);
        end
        expect_reg(req, A_SWRST, 16'h0001);
    endtask

    task automatic t_por;
        repeat (4) @(negedge clk);
        chk("R2", "outputs during por", {14'b0, rst_dig_o, rst_ret_o}, 16'h3);
        por_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R2", "ret held after por", {15'b0, rst_ret_o}, 16'h1);
            @(negedge clk);
        end
        chk("R2", "outputs released", {14'b0, rst_dig_o, rst_ret_o}, 16'h0);
        expect_reg("R2", A_CAUSE, 16'h0001);
        expect_reg("R2", A_SWRST, 16'h0001);
        expect_reg("R1", A_KEY, 16'h0000);
        expect_reg("R1", 12'h000, 16'h0000);
    endtask

    task automatic t_sw_reset;
        bus_write(A_KEY, KEY);
        bus_write(A_SWRST, 16'hFFFE);
        for (int i = 0; i < 8; i++) begin
            chk("R4", "dig held", {15'b0, rst_dig_o}, 16'h1);
            chk("R4", "ret untouched", {15'b0, rst_ret_o}, 16'h0);
            if (i == 3) expect_reg("R5", A_SWRST, 16'h0000);
            @(negedge clk);
        end
        chk("R4", "dig released after 8", {15'b0, rst_dig_o}, 16'h0);
        expect_reg("R5", A_SWRST, 16'h0001);
        expect_reg("R11", A_CAUSE, 16'h0009);
    endtask

    task automatic t_w1c;
        bus_write(A_CAUSE, 16'h0000);
        expect_reg("R9", A_CAUSE, 16'h0009);
        bus_write(A_CAUSE, 16'h0008);
        expect_reg("R9", A_CAUSE, 16'h0001);
    endtask

    task automatic t_wrong_key;
        bus_write(A_KEY, 16'h12EB);
        bus_write(A_SWRST, 16'h0000);
        expect_no_reset("R6");
        expect_reg("R6", A_CAUSE, 16'h0001);
    endtask

    task automatic t_locked;
        bus_write(A_SWRST, 16'h0000);
        expect_no_reset("R6");
    endtask

    task automatic t_relock;
        bus_write(A_KEY, KEY);
        bus_write(A_CAUSE, 16'h0000);
        bus_write(A_SWRST, 16'h0000);
        expect_no_reset("R7");
    endtask

    task automatic t_one_shot;
        bus_write(A_KEY, KEY);
        bus_write(A_SWRST, 16'h0001);
        expect_no_reset("R8");
        bus_write(A_SWRST, 16'h0000);
        expect_no_reset("R8");
    endtask

    task automatic t_writes_blocked;
        bus_write(A_KEY, KEY);
        bus_write(A_SWRST, 16'h0000);
        bus_write(A_CAUSE, 16'hFFFF);
        bus_write(A_KEY, KEY);
        repeat (8) @(negedge clk);
        chk("R10", "dig released", {15'b0, rst_dig_o}, 16'h0);
        expect_reg("R10", A_CAUSE, 16'h0009);
        bus_write(A_SWRST, 16'h0000);
        expect_no_reset("R10");
        bus_write(A_KEY, KEY);
        bus_write(A_SWRST, 16'h0000);
        repeat (10) @(negedge clk);
        expect_reg("R8", A_CAUSE, 16'h0009);
    endtask

    task automatic t_ext;
        @(negedge clk);
        ext_rst_n_i = 1'b0;
        #0.5;
        chk("R3", "async assert", {14'b0, rst_dig_o, rst_ret_o}, 16'h3);
        repeat (4) @(negedge clk);
        ext_rst_n_i = 1'b1;
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            chk("R3", $sformatf("held edge %0d", i), {14'b0, rst_dig_o, rst_ret_o}, 16'h3);
        end
        @(negedge clk);
        chk("R3", "released at edge 10", {14'b0, rst_dig_o, rst_ret_o}, 16'h0);
        expect_reg("R11", A_CAUSE, 16'h000B);
        bus_write(A_CAUSE, 16'hFFFF);
        expect_reg("R9", A_CAUSE, 16'h0000);
    endtask

    initial begin
        t_por();
        t_sw_reset();
        t_w1c();
        t_wrong_key();
        t_locked();
        t_relock();
        t_one_shot();
        t_writes_blocked();
        t_ext();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule